// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This unit carries out one vector-configuration instruction per execute strobe. The instruction brings a requested element-width code, a 3-bit length-multiplier code, an application vector length and two flags. The flags say whether the source register and the destination register are the zero register. The unit holds the architectural vtype state, made up of an element width, a multiplier and an illegal flag, together with the current vector length. It works out the maximum vector length for the configuration from a parameterized register length. It then writes the new length and type, or it raises a trap request and leaves both untouched.

One multiplier code does not name a multiplier. It asks the unit to derive one so that the current ratio of element width to multiplier is kept, and with it the maximum length. A derived multiplier may reach 1/16, which no explicit code can request. The unit stores that value and reports it in the vtype outputs. A request that the hardware cannot support sets the illegal flag and does not trap. Three specific misuse cases raise a precise trap instead.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is active, and after it is released, vtype is illegal: the illegal flag is 1 and the width and multiplier fields are 0. The vector length is 0, the maximum length is 0 and the trap output is 0.
- R2: Width codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. The multiplier field is the 3-bit two's complement of log2(LMUL), so 0, 1, 2 and 3 mean 1, 2, 4 and 8, and 7, 6, 5 and 4 mean 1/2, 1/4, 1/8 and 1/16. The maximum-length output equals VLEN / SEW × LMUL for the stored vtype, and it is 0 while vtype is illegal.
- R3: When the source is not the zero register, the new length is the smaller of the requested length and the new maximum length. The length never exceeds the maximum-length output.
- R4: When the source is the zero register and the destination is not, the new length equals the new maximum length.
- R5: When both registers are the zero register, the current length is the request, and the new maximum is unchanged, the length keeps its value.
- R6: Input multiplier code 4 is the derive code. The new multiplier is the new width times the old multiplier divided by the old width, so the maximum length is unchanged.
- R7: A derived multiplier of 1/16 is stored and reported as field code 4.
- R8: An explicit request whose width is unsupported (code above log2(ELEN)−3), or whose maximum length would be below one element, sets the illegal flag. It clears width, multiplier and length to 0 and does not trap.
- R9: Using the derive code while vtype is illegal traps.
- R10: Using the derive code when the derived multiplier falls outside 1/16 to 8 traps.
- R11: Both registers being the zero register with an explicit multiplier traps if the maximum length would change. An illegal type counts as maximum length 0 in this comparison.
- R12: Every result appears on the clock edge that samples the execute strobe. On a trap, the length and type keep their old values and the trap output is high for exactly that one cycle. Without the strobe, all state holds and the trap output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one instruction per high cycle |
| req_sew_i | input | 3 | Requested element-width code |
| req_lmul_i | input | 3 | Requested multiplier code, 4 = derive |
| avl_i | input | XLEN | Application vector length from the source register |
| rs1_zero_i | input | 1 | Source register is the zero register |
| rd_zero_i | input | 1 | Destination register is the zero register |
| vl_o | output | log2(VLEN)+1 | Current vector length |
| vtype_ill_o | output | 1 | Illegal-configuration flag |
| vtype_sew_o | output | 3 | Stored element-width code |
| vtype_lmul_o | output | 3 | Stored multiplier code |
| vlmax_o | output | log2(VLEN)+1 | Maximum length for the stored vtype |
| trap_o | output | 1 | Trap request, one cycle |

## Verification
A corrupted width or multiplier field shows up on vlmax_o in the same cycle, because that output is computed directly from the stored type. A stale length shows up on vl_o one edge after the faulty instruction. Errors in derivation stay hidden until a later derive step or a keep-length step reads the old ratio. For that reason the bench chains derive steps and zero-register steps. A wrongly taken or missed trap shows up in the same edge, on trap_o and as a change, or a missing change, in vl_o and the vtype outputs.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  // Input multiplier code that asks for derivation instead of a value.
  localparam logic [2:0] LMUL_DERIVE = 3'b100;

  typedef struct packed {
    logic       bad;   // illegal configuration
    logic [2:0] sew;   // element-width code, SEW = 8 << sew
    logic [2:0] lmul;  // two's complement log2 of the multiplier
  } vtype_t;

  localparam vtype_t VTYPE_BAD = '{bad: 1'b1, sew: 3'd0, lmul: 3'd0};

  // Multiplier field to signed log2 (sign extension of the field).
  function automatic logic signed [3:0] lmul_log2(input logic [2:0] code);
    return signed'({code[2], code});
  endfunction

endpackage

// File: rtl/vcfg_sew_check.sv
module vcfg_sew_check #(
  parameter int ELEN = 64
) (
  input  logic [2:0] sew_i,
  output logic       ok_o
);
  localparam int MAX_CODE = $clog2(ELEN) - 3;

  always_comb begin
    ok_o = ({1'b0, sew_i} <= 4'(MAX_CODE));
  end
endmodule

// File: rtl/vcfg_vlmax_calc.sv
module vcfg_vlmax_calc #(
  parameter int VLEN = 128,
  parameter int VL_W = $clog2(VLEN) + 1
) (
  input  logic              [2:0]      sew_i,
  input  logic signed       [3:0]      lmul_log_i,
  output logic              [VL_W-1:0] vlmax_o,
  output logic                         fits_o
);
  localparam int VLEN_LOG = $clog2(VLEN);

  logic [7:0] expo;

  // log2(VLMAX) = log2(VLEN) - (3 + sew) + log2(LMUL)
  always_comb begin
    expo = 8'(VLEN_LOG) - 8'd3 - {5'd0, sew_i} + {{4{lmul_log_i[3]}}, lmul_log_i};
    fits_o  = ~expo[7];
    vlmax_o = fits_o ? (VL_W'(1) << expo[6:0]) : '0;
  end
endmodule

// File: rtl/vcfg_derive.sv
module vcfg_derive (
  input  logic        [2:0] new_sew_i,
  input  logic        [2:0] old_sew_i,
  input  logic signed [3:0] old_lmul_log_i,
  output logic signed [3:0] lmul_log_o,
  output logic              in_range_o
);
  logic [5:0] sum;

  // New log2(LMUL) = old log2(LMUL) + (new log2 SEW - old log2 SEW)
  always_comb begin
    sum = {3'd0, new_sew_i} - {3'd0, old_sew_i} + {{2{old_lmul_log_i[3]}}, old_lmul_log_i};
    in_range_o = ($signed(sum) >= -6'sd4) && ($signed(sum) <= 6'sd3);
    lmul_log_o = signed'(sum[3:0]);
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 32,
  localparam int VL_W = $clog2(VLEN) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic [2:0]      req_sew_i,
  input  logic [2:0]      req_lmul_i,
  input  logic [XLEN-1:0] avl_i,
  input  logic            rs1_zero_i,
  input  logic            rd_zero_i,
  output logic [VL_W-1:0] vl_o,
  output logic            vtype_ill_o,
  output logic [2:0]      vtype_sew_o,
  output logic [2:0]      vtype_lmul_o,
  output logic [VL_W-1:0] vlmax_o,
  output logic            trap_o
);

  vtype_t          vtype_q, vtype_d;
  logic [VL_W-1:0] vl_q, vl_d;
  logic            trap_q, trap_d;

  // ---------------- current configuration ----------------
  logic [VL_W-1:0] cur_vlmax_raw, cur_vlmax;
  logic            cur_fits;

  vcfg_vlmax_calc #(.VLEN(VLEN), .VL_W(VL_W)) u_cur_vlmax (
    .sew_i      (vtype_q.sew),
    .lmul_log_i (lmul_log2(vtype_q.lmul)),
    .vlmax_o    (cur_vlmax_raw),
    .fits_o     (cur_fits)
  );

  assign cur_vlmax = (vtype_q.bad || !cur_fits) ? '0 : cur_vlmax_raw;

  // ---------------- requested configuration ----------------
  logic               is_derive;
  logic               sew_ok;
  logic signed [3:0]  der_log;
  logic               der_ok;
  logic signed [3:0]  new_log;
  logic [VL_W-1:0]    new_vlmax_raw, new_vlmax;
  logic               new_fits, new_legal;

  assign is_derive = (req_lmul_i == LMUL_DERIVE);

  vcfg_sew_check #(.ELEN(ELEN)) u_sew_check (
    .sew_i (req_sew_i),
    .ok_o  (sew_ok)
  );

  vcfg_derive u_derive (
    .new_sew_i      (req_sew_i),
    .old_sew_i      (vtype_q.sew),
    .old_lmul_log_i (lmul_log2(vtype_q.lmul)),
    .lmul_log_o     (der_log),
    .in_range_o     (der_ok)
  );

  assign new_log = is_derive ? der_log : lmul_log2(req_lmul_i);

  vcfg_vlmax_calc #(.VLEN(VLEN), .VL_W(VL_W)) u_new_vlmax (
    .sew_i      (req_sew_i),
    .lmul_log_i (new_log),
    .vlmax_o    (new_vlmax_raw),
    .fits_o     (new_fits)
  );

  assign new_legal = sew_ok && new_fits && (!is_derive || der_ok);
  assign new_vlmax = new_legal ? new_vlmax_raw : '0;

  // ---------------- trap decision ----------------
  logic trap_bad_src, trap_range, trap_keep, trap_any;

  assign trap_bad_src = is_derive && vtype_q.bad;                        // R9
  assign trap_range   = is_derive && !vtype_q.bad && !der_ok;            // R10
  assign trap_keep    = !is_derive && rs1_zero_i && rd_zero_i
                        && (new_vlmax != cur_vlmax);                     // R11
  assign trap_any     = trap_bad_src || trap_range || trap_keep;

  // ---------------- new length ----------------
  logic [XLEN-1:0] avl_sel;
  logic [VL_W-1:0] vl_new;

  always_comb begin
    if (!rs1_zero_i)     avl_sel = avl_i;
    else if (!rd_zero_i) avl_sel = XLEN'(new_vlmax);
    else                 avl_sel = XLEN'(vl_q);
    vl_new = (avl_sel < XLEN'(new_vlmax)) ? avl_sel[VL_W-1:0] : new_vlmax;
  end

  // ---------------- next state ----------------
  always_comb begin
    vtype_d = vtype_q;
    vl_d    = vl_q;
    trap_d  = 1'b0;
    if (exec_i) begin
      if (trap_any) begin
        trap_d = 1'b1;
      end else if (new_legal) begin
        vtype_d = '{bad: 1'b0, sew: req_sew_i, lmul: new_log[2:0]};
        vl_d    = vl_new;
      end else begin
        vtype_d = VTYPE_BAD;
        vl_d    = '0;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vtype_q <= VTYPE_BAD;
      vl_q    <= '0;
      trap_q  <= 1'b0;
    end else begin
      vtype_q <= vtype_d;
      vl_q    <= vl_d;
      trap_q  <= trap_d;
    end
  end

  assign vl_o         = vl_q;
  assign vtype_ill_o  = vtype_q.bad;
  assign vtype_sew_o  = vtype_q.sew;
  assign vtype_lmul_o = vtype_q.lmul;
  assign vlmax_o      = cur_vlmax;
  assign trap_o       = trap_q;

  // ---------------- assertions ----------------
  // R9, R10, R11: a trapping instruction leaves length and type untouched
  assert_trap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && trap_any) |=> (trap_o && $stable(vl_o) && $stable(vtype_ill_o)
                              && $stable(vtype_sew_o) && $stable(vtype_lmul_o)));

  assert_bad_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_ill_o |-> (vtype_sew_o == 3'd0 && vtype_lmul_o == 3'd0 && vl_o == '0));

  assert_vl_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= vlmax_o);

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> (!trap_o && $stable(vl_o) && $stable(vtype_ill_o)
                 && $stable(vtype_sew_o) && $stable(vtype_lmul_o)));

  assert_derive_ratio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && is_derive && !trap_any) |=> (vtype_ill_o || vlmax_o == $past(vlmax_o)));

endmodule

// File: tb/sim_vcfg_unit.sv
module sim_vcfg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VL_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            exec;
  logic [2:0]      sew, lmul;
  logic [31:0]     avl;
  logic            r1z, rdz;
  logic [VL_W-1:0] vl, vlmax;
  logic            ill, trap;
  logic [2:0]      vsew, vlmul;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [VL_W-1:0] vl;
    logic            ill;
    logic [2:0]      sew;
    logic [2:0]      lmul;
    logic [VL_W-1:0] vlmax;
    logic            trap;
    string           tag;
  } exp_t;

  exp_t q[$];
  logic pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcfg_unit #(.VLEN(128), .ELEN(64), .XLEN(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec),
    .req_sew_i(sew), .req_lmul_i(lmul), .avl_i(avl),
    .rs1_zero_i(r1z), .rd_zero_i(rdz),
    .vl_o(vl), .vtype_ill_o(ill), .vtype_sew_o(vsew), .vtype_lmul_o(vlmul),
    .vlmax_o(vlmax), .trap_o(trap)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (vl !== e.vl || ill !== e.ill || vsew !== e.sew || vlmul !== e.lmul
        || vlmax !== e.vlmax || trap !== e.trap) begin
      failures++;
      $display("FAIL %s: got vl=%0d ill=%0d sew=%0d lmul=%0d vlmax=%0d trap=%0d exp vl=%0d ill=%0d sew=%0d lmul=%0d vlmax=%0d trap=%0d",
               e.tag, vl, ill, vsew, vlmul, vlmax, trap,
               e.vl, e.ill, e.sew, e.lmul, e.vlmax, e.trap);
    end
  endtask

  // Monitor: the result of an instruction is visible after the edge that sampled it
  always @(posedge clk) pend <= exec;

  always @(negedge clk) begin
    if (pend) begin
      if (q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        compare(q.pop_front());
      end
    end
  end

  task automatic issue(input logic [2:0] s, input logic [2:0] l, input logic [31:0] a,
                       input logic z1, input logic zd,
                       input logic [VL_W-1:0] evl, input logic eill,
                       input logic [2:0] esew, input logic [2:0] elmul,
                       input logic [VL_W-1:0] evlmax, input logic etrap, input string tag);
    exp_t e;
    @(negedge clk);
    sew = s; lmul = l; avl = a; r1z = z1; rdz = zd; exec = 1'b1;
    e.vl = evl; e.ill = eill; e.sew = esew; e.lmul = elmul;
    e.vlmax = evlmax; e.trap = etrap; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; exec = 1'b0; sew = '0; lmul = '0; avl = '0; r1z = 1'b0; rdz = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r.vl = 0; r.ill = 1; r.sew = 0; r.lmul = 0; r.vlmax = 0; r.trap = 0; r.tag = "R1 reset";
    compare(r);

    // VLEN=128: VLMAX = 2^(4 - sewcode + log2 LMUL)
    issue(3'd2, 3'd0, 32'd3,    0, 0, 8'd3,   0, 3'd2, 3'd0, 8'd4,   0, "R3 e32 m1 avl below max");
    issue(3'd2, 3'd0, 32'd10,   0, 0, 8'd4,   0, 3'd2, 3'd0, 8'd4,   0, "R3 e32 m1 clipped");
    issue(3'd0, 3'd3, 32'd1000, 0, 0, 8'd128, 0, 3'd0, 3'd3, 8'd128, 0, "R2 e8 m8 full length");
    issue(3'd1, 3'd1, 32'd2,    1, 0, 8'd16,  0, 3'd1, 3'd1, 8'd16,  0, "R4 source zero takes max");
    issue(3'd2, 3'd4, 32'd20,   0, 0, 8'd16,  0, 3'd2, 3'd2, 8'd16,  0, "R6 derive e32 gives m4");
    issue(3'd0, 3'd4, 32'd5,    0, 0, 8'd5,   0, 3'd0, 3'd0, 8'd16,  0, "R6 derive e8 gives m1");
    issue(3'd1, 3'd5, 32'd9,    0, 0, 8'd1,   0, 3'd1, 3'd5, 8'd1,   0, "R2 e16 mf8 one element");
    issue(3'd0, 3'd4, 32'd3,    0, 0, 8'd1,   0, 3'd0, 3'd4, 8'd1,   0, "R7 derive to 1/16");
    issue(3'd0, 3'd4, 32'd3,    0, 0, 8'd1,   0, 3'd0, 3'd4, 8'd1,   0, "R7 derive from 1/16");
    issue(3'd3, 3'd5, 32'd4,    0, 0, 8'd0,   1, 3'd0, 3'd0, 8'd0,   0, "R8 below one element");
    issue(3'd2, 3'd4, 32'd4,    0, 0, 8'd0,   1, 3'd0, 3'd0, 8'd0,   1, "R9 derive while illegal");
    issue(3'd0, 3'd3, 32'd50,   0, 0, 8'd50,  0, 3'd0, 3'd3, 8'd128, 0, "R3 e8 m8 avl 50");
    issue(3'd3, 3'd4, 32'd5,    0, 0, 8'd50,  0, 3'd0, 3'd3, 8'd128, 1, "R10 derive beyond m8");
    issue(3'd5, 3'd0, 32'd4,    0, 0, 8'd0,   1, 3'd0, 3'd0, 8'd0,   0, "R8 unsupported width");
    issue(3'd2, 3'd0, 32'd3,    0, 0, 8'd3,   0, 3'd2, 3'd0, 8'd4,   0, "R3 e32 m1 again");
    issue(3'd0, 3'd0, 32'd9,    1, 1, 8'd3,   0, 3'd2, 3'd0, 8'd4,   1, "R11 keep-length max change");
    issue(3'd1, 3'd7, 32'd9,    1, 1, 8'd3,   0, 3'd1, 3'd7, 8'd4,   0, "R5 keep-length same max");
    issue(3'd3, 3'd4, 32'd9,    1, 1, 8'd3,   0, 3'd3, 3'd1, 8'd4,   0, "R6 keep-length derive");

    // R12: no strobe, inputs wiggled, nothing may change
    @(negedge clk);
    sew = 3'd0; lmul = 3'd3; avl = 32'd77; r1z = 1'b0; rdz = 1'b0;
    repeat (3) @(negedge clk);
    r.vl = 3; r.ill = 0; r.sew = 3; r.lmul = 1; r.vlmax = 4; r.trap = 0; r.tag = "R12 idle hold";
    compare(r);
    lmul = 3'd4; r1z = 1'b1; rdz = 1'b1;
    repeat (2) @(negedge clk);
    r.tag = "R12 idle hold derive inputs";
    compare(r);

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: %0d results missing, expected 0", q.size());
    end
    finish_run();
  end
endmodule